// File: doc/BRIEF.md
# Maskable Interrupt Status Unit

This block gathers event indications from a flash transfer engine into a small set of status bits and turns them into one interrupt line. Two of the events, transfer completion and chip-select release, arrive as single-cycle pulses. These are held in sticky bits until software clears them by writing ones. The other two are the read-buffer-ready and write-buffer-ready conditions. They are levels, and their status bits follow the live buffer state instead of being latched.

Two mask layers shape the result. The capture-enable register decides whether an event is allowed into the status word at all. The line-enable register decides which visible status bits take part in driving the interrupt output. Software reaches the three registers through a plain word-addressed write strobe, address and data port. Reads are combinational and return the register selected by the address.

Top module: `irq_status_unit`

## Requirements
- R1: After a synchronous active-low reset, the status word, the capture-enable register and the line-enable register all read as zero, and `irq_out` is low.
- R2: A pulse on `evt_xfer_done` or `evt_cs_release` sets its sticky status bit only if the matching capture-enable bit is 1 on that clock edge. Once set, the bit stays set without further pulses.
- R3: The status bit positions are: bit 0 transfer complete, bit 1 read buffer ready, bit 2 write buffer ready, bit 8 chip-select release. Word address 0 is status, address 1 is capture-enable and address 2 is line-enable. Address 3 and all other bit positions read as 0.
- R4: Writing address 0 with a 1 in bit 0 or bit 8 clears that sticky bit. A 0 in a bit leaves it unchanged.
- R5: If an event pulse and a write-one clear hit the same sticky bit on the same edge, the bit ends up set.
- R6: Status bits 1 and 2 read as the current `rd_buf_ready` and `wr_buf_ready` levels ANDed with their capture-enable bits. They are never latched, and writes to them at address 0 have no effect.
- R7: `irq_out` is a register. Its value equals the OR, over all bit positions, of the visible status word ANDed with line-enable, as sampled one edge earlier.
- R8: Both enable registers are read/write. A write stores bits 0, 1, 2 and 8 of the data word and drops all other bits.
- R9: Clearing a capture-enable bit does not remove a sticky bit that is already set; it only blocks new captures.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address of the register to access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| evt_xfer_done | input | 1 | Single-cycle pulse: transfer complete |
| evt_cs_release | input | 1 | Single-cycle pulse: chip select released |
| rd_buf_ready | input | 1 | Level: read buffer holds data |
| wr_buf_ready | input | 1 | Level: write buffer can accept data |
| irq_out | output | 1 | Registered interrupt line |

## Verification
The hardest case to reach is the same-edge collision, where a completion pulse and a write-one clear of the same bit land on one clock edge. The bench reaches it by driving the pulse and the status write together on one negative edge, so both are sampled by the same rising edge. It then reads the bit back. The registered interrupt line also needs care. The bench checks it on the edge where the status changes, to confirm it has not yet moved, and again one edge later, to confirm that it has.

// File: rtl/irqs_pkg.sv
// Package irqs_pkg
// Holds the shared constants of the interrupt status unit: data width,
// register word addresses and the status bit positions that software decodes.
package irqs_pkg;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned ADDR_W   = 2;

    // Status bit positions, fixed because software decodes them.
    localparam int unsigned BIT_DONE  = 0;
    localparam int unsigned BIT_RDRDY = 1;
    localparam int unsigned BIT_WRRDY = 2;
    localparam int unsigned BIT_CSREL = 8;

    // Sticky (pulse-captured) bits, in the order of the event vector.
    localparam int unsigned N_STICKY = 2;
    localparam int unsigned STICKY_POS [N_STICKY] = '{BIT_DONE, BIT_CSREL};

    // Bits that are implemented in the enable registers and the status word.
    localparam logic [DATA_W-1:0] IMPL_MASK =
        (DATA_W'(1) << BIT_DONE)  | (DATA_W'(1) << BIT_RDRDY) |
        (DATA_W'(1) << BIT_WRRDY) | (DATA_W'(1) << BIT_CSREL);

    // Register word addresses.
    localparam logic [ADDR_W-1:0] A_STATUS  = 2'd0;
    localparam logic [ADDR_W-1:0] A_CAP_EN  = 2'd1;
    localparam logic [ADDR_W-1:0] A_LINE_EN = 2'd2;
endpackage

// File: rtl/irqs_sticky_bit.sv
// Module irqs_sticky_bit
// One latched status bit. Set wins over clear on the same edge.
// Assumes set_i is already gated by its capture enable.
module irqs_sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    // Hold the bit; a set beats a clear on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_o <= 1'b0;
        else if (set_i)
            q_o <= 1'b1;
        else if (clr_i)
            q_o <= 1'b0;
    end
endmodule

// File: rtl/irqs_regfile.sv
// Module irqs_regfile
// Holds the capture-enable and line-enable registers and builds the read
// data. Only implemented bits are stored. Assumes status_i is the visible
// status word, already masked to the implemented bits.
module irqs_regfile
    import irqs_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    parameter int unsigned AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [DW-1:0] status_i,
    output logic [DW-1:0] cap_en_o,
    output logic [DW-1:0] line_en_o,
    output logic [DW-1:0] rdata_o
);
    localparam logic [DW-1:0] MASK = DW'(IMPL_MASK);

    // Capture-enable register with masked writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cap_en_o <= '0;
        else if (we_i && addr_i == AW'(A_CAP_EN))
            cap_en_o <= wdata_i & MASK;
    end

    // Line-enable register with masked writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            line_en_o <= '0;
        else if (we_i && addr_i == AW'(A_LINE_EN))
            line_en_o <= wdata_i & MASK;
    end

    // Read multiplexer; unmapped addresses return zero.
    always_comb begin
        unique case (addr_i)
            AW'(A_STATUS):  rdata_o = status_i;
            AW'(A_CAP_EN):  rdata_o = cap_en_o;
            AW'(A_LINE_EN): rdata_o = line_en_o;
            default:        rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/irqs_line_gen.sv
// Module irqs_line_gen
// Registers the OR of the status bits that are line-enabled.
// Assumes both inputs are the same width and already masked.
module irqs_line_gen #(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] status_i,
    input  logic [DW-1:0] line_en_i,
    output logic          irq_o
);
    // One register stage after the reduce-OR.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_o <= 1'b0;
        else
            irq_o <= |(status_i & line_en_i);
    end
endmodule

// File: rtl/irq_status_unit.sv
// Module irq_status_unit
// Collects engine events into status bits behind two mask layers and
// drives one registered interrupt line. Pulse events are sticky and cleared
// by writing one; buffer-ready levels are shown live, gated by capture enable.
// Assumes event pulses are single-cycle and synchronous to clk.
module irq_status_unit
    import irqs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              evt_xfer_done,
    input  logic              evt_cs_release,
    input  logic              rd_buf_ready,
    input  logic              wr_buf_ready,
    output logic              irq_out
);
    logic [DATA_W-1:0]   cap_en_q;
    logic [DATA_W-1:0]   line_en_q;
    logic [DATA_W-1:0]   status_view;
    logic [N_STICKY-1:0] sticky_q;
    logic [N_STICKY-1:0] evt_vec;
    logic                status_wr;

    assign evt_vec   = {evt_cs_release, evt_xfer_done};
    assign status_wr = reg_we && (reg_addr == A_STATUS);

    // One sticky bit for each pulse event, placed at its status position.
    for (genvar g = 0; g < N_STICKY; g++) begin : g_sticky
        irqs_sticky_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (evt_vec[g] & cap_en_q[STICKY_POS[g]]),
            .clr_i (status_wr & reg_wdata[STICKY_POS[g]]),
            .q_o   (sticky_q[g])
        );
    end

    // Assemble the visible status word from sticky bits and live levels.
    always_comb begin
        status_view = '0;
        for (int i = 0; i < int'(N_STICKY); i++)
            status_view[STICKY_POS[i]] = sticky_q[i];
        status_view[BIT_RDRDY] = rd_buf_ready & cap_en_q[BIT_RDRDY];
        status_view[BIT_WRRDY] = wr_buf_ready & cap_en_q[BIT_WRRDY];
    end

    irqs_regfile #(.DW(DATA_W), .AW(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (reg_we),
        .addr_i    (reg_addr),
        .wdata_i   (reg_wdata),
        .status_i  (status_view),
        .cap_en_o  (cap_en_q),
        .line_en_o (line_en_q),
        .rdata_o   (reg_rdata)
    );

    irqs_line_gen #(.DW(DATA_W)) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .status_i  (status_view),
        .line_en_i (line_en_q),
        .irq_o     (irq_out)
    );
endmodule

// File: rtl/irq_status_unit_chk.sv
// Module irq_status_unit_chk
// Checker bound to irq_status_unit. It relates events, register writes,
// the internal sticky and enable state and the interrupt line over time.
module irq_status_unit_chk
    import irqs_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              evt_xfer_done,
    input logic              evt_cs_release,
    input logic              rd_buf_ready,
    input logic [N_STICKY-1:0] sticky_q,
    input logic [DATA_W-1:0] cap_en_q,
    input logic [DATA_W-1:0] line_en_q,
    input logic [DATA_W-1:0] status_view,
    input logic              irq_out
);
    // R2: the completion bit only rises after an enabled event.
    a_r2_done_gated: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(sticky_q[0])) |->
            $past(evt_xfer_done && cap_en_q[BIT_DONE]));

    // R4: a write-one clear without a competing event drops the bit.
    a_r4_w1c_done: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_STATUS && reg_wdata[BIT_DONE] && !evt_xfer_done)
            |=> !sticky_q[0]);

    // R5: an enabled release event sets the bit even under a clear.
    a_r5_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_cs_release && cap_en_q[BIT_CSREL]) |=> sticky_q[1]);

    // R6: the read-ready status bit is never shown without the level.
    a_r6_level_only: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_buf_ready |-> !status_view[BIT_RDRDY]);

    // R7: the line follows the enabled status one edge later.
    a_r7_line_reg: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq_out == $past(|(status_view & line_en_q))));

    // R8: the enable registers never hold unimplemented bits.
    a_r8_masked_en: assert property (@(posedge clk) disable iff (!rst_n)
        ((cap_en_q & ~IMPL_MASK) == '0) && ((line_en_q & ~IMPL_MASK) == '0));
endmodule

bind irq_status_unit irq_status_unit_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .reg_we         (reg_we),
    .reg_addr       (reg_addr),
    .reg_wdata      (reg_wdata),
    .evt_xfer_done  (evt_xfer_done),
    .evt_cs_release (evt_cs_release),
    .rd_buf_ready   (rd_buf_ready),
    .sticky_q       (sticky_q),
    .cap_en_q       (cap_en_q),
    .line_en_q      (line_en_q),
    .status_view    (status_view),
    .irq_out        (irq_out)
);

// File: tb/tb_irq_status_unit.sv
module tb_irq_status_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        evt_xfer_done = 1'b0;
    logic        evt_cs_release = 1'b0;
    logic        rd_buf_ready = 1'b0;
    logic        wr_buf_ready = 1'b0;
    logic        irq_out;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    irq_status_unit dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_xfer_done(evt_xfer_done), .evt_cs_release(evt_cs_release),
        .rd_buf_ready(rd_buf_ready), .wr_buf_ready(wr_buf_ready),
        .irq_out(irq_out)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Advance one rising edge and settle.
    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd_check(string tag, logic [1:0] a, logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1 check(tag, reg_rdata, exp);
    endtask

    task automatic pulse(bit done, bit cs);
        @(negedge clk);
        evt_xfer_done = done; evt_cs_release = cs;
        tick();
        evt_xfer_done = 1'b0; evt_cs_release = 1'b0;
    endtask

    task automatic t_reset();
        rd_check("R1 status", 2'd0, 32'h0);
        rd_check("R1 cap_en", 2'd1, 32'h0);
        rd_check("R1 line_en", 2'd2, 32'h0);
        check("R1 irq", {31'd0, irq_out}, 32'h0);
    endtask

    task automatic t_enables();
        wr(2'd1, 32'hFFFF_FFFF);
        rd_check("R8 cap_en mask", 2'd1, 32'h0000_0107);
        wr(2'd2, 32'hFFFF_FEFA);
        rd_check("R8 line_en mask", 2'd2, 32'h0000_0002);
        rd_check("R3 addr3 zero", 2'd3, 32'h0);
        wr(2'd1, 32'h0); wr(2'd2, 32'h0);
    endtask

    task automatic t_masked_event();
        pulse(1, 1);
        rd_check("R2 masked events", 2'd0, 32'h0);
    endtask

    task automatic t_latch();
        wr(2'd1, 32'h0000_0101);
        pulse(1, 0);
        rd_check("R2 done latched", 2'd0, 32'h0000_0001);
        tick(); tick();
        rd_check("R2 done holds", 2'd0, 32'h0000_0001);
        pulse(0, 1);
        rd_check("R3 cs bit8", 2'd0, 32'h0000_0101);
    endtask

    task automatic t_w1c();
        wr(2'd0, 32'hFFFF_FEFE);
        rd_check("R4 zero bits keep", 2'd0, 32'h0000_0101);
        wr(2'd0, 32'h0000_0001);
        rd_check("R4 clear bit0", 2'd0, 32'h0000_0100);
        wr(2'd0, 32'h0000_0100);
        rd_check("R4 clear bit8", 2'd0, 32'h0000_0000);
    endtask

    task automatic t_event_wins();
        pulse(1, 0);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h0000_0101;
        evt_xfer_done = 1'b1;
        tick();
        reg_we = 1'b0; reg_wdata = '0; evt_xfer_done = 1'b0;
        rd_check("R5 event wins", 2'd0, 32'h0000_0001);
        wr(2'd0, 32'h0000_0001);
    endtask

    task automatic t_level();
        wr(2'd1, 32'h0000_0006);
        @(negedge clk); rd_buf_ready = 1'b1;
        rd_check("R6 rd level", 2'd0, 32'h0000_0002);
        wr(2'd0, 32'h0000_0006);
        rd_check("R6 w1c ignored", 2'd0, 32'h0000_0002);
        @(negedge clk); rd_buf_ready = 1'b0; wr_buf_ready = 1'b1;
        rd_check("R6 follows level", 2'd0, 32'h0000_0004);
        wr(2'd1, 32'h0);
        rd_check("R6 gated by cap_en", 2'd0, 32'h0);
        @(negedge clk); wr_buf_ready = 1'b0;
    endtask

    task automatic t_irq();
        wr(2'd1, 32'h0000_0103);
        wr(2'd2, 32'h0000_0001);
        pulse(1, 0);
        check("R7 irq not yet", {31'd0, irq_out}, 32'h0);
        tick();
        check("R7 irq set", {31'd0, irq_out}, 32'h1);
        wr(2'd0, 32'h0000_0001);
        check("R7 irq lags clear", {31'd0, irq_out}, 32'h1);
        tick();
        check("R7 irq cleared", {31'd0, irq_out}, 32'h0);
        pulse(0, 1); tick(); tick();
        check("R7 line-masked bit8", {31'd0, irq_out}, 32'h0);
        wr(2'd0, 32'h0000_0100);
        wr(2'd2, 32'h0000_0002);
        @(negedge clk); rd_buf_ready = 1'b1;
        tick(); tick();
        check("R7 level irq", {31'd0, irq_out}, 32'h1);
        @(negedge clk); rd_buf_ready = 1'b0;
        tick(); tick();
        check("R7 level irq drop", {31'd0, irq_out}, 32'h0);
        wr(2'd2, 32'h0);
    endtask

    task automatic t_persist();
        wr(2'd1, 32'h0000_0001);
        pulse(1, 0);
        wr(2'd1, 32'h0);
        rd_check("R9 kept after disable", 2'd0, 32'h0000_0001);
        wr(2'd0, 32'h0000_0001);
        pulse(1, 0);
        rd_check("R9 no new capture", 2'd0, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 t_reset();
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_enables();
        t_masked_event();
        t_latch();
        t_w1c();
        t_event_wins();
        t_level();
        t_irq();
        t_persist();
        finished = 1'b1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (20000) @(posedge clk);
                n_checks++; n_errors++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule